// File: doc/BRIEF.md
# Serial Core Run-State Controller

This block sits in front of a serial peripheral's data path and decides when that data path may move words. Software drives it through a small register port. It writes a target state (reset, run, pause or a one-shot clear) and polls a VALID bit. VALID drops while a transition settles and rises again once the settle time has passed and the data path has confirmed it is ready.

The controller also holds the two transfer-count limits, one for the transmit direction and one for the receive direction. These can only be programmed while the core is in reset. The data path reports each word it moves through a one-cycle pulse. The controller counts these pulses only while running, freezes the counts while paused, and raises a sticky done flag for each direction when its limit is reached. Leaving the run state for reset or clear flushes the FIFOs with a one-cycle pulse. A software-reset register restores every setting to its default.

Top module: `scc_run_ctrl`

## Requirements
- R1: After hardware reset the state register (address 0) reads state 0 (reset) with VALID (bit 2) at 1. The count limits (addresses 2 and 3) and the status register (address 4) read 0. `out_en`, `in_en` and `fifo_flush` are low.
- R2: A write to address 0 while VALID is 1 is accepted. The state field (bits 1:0, encoded reset=0, run=1, clear=2, pause=3) shows the new state in the cycle after the write edge. VALID then reads 0 for SETTLE cycles (3 by default). After that, VALID stays 0 for as long as `dp_ready` is low, and returns to 1 on the first clock edge that sees `dp_ready` high.
- R3: The transmit limit (address 2) and receive limit (address 3) are 16-bit registers. They take a write only while the state is reset. A write in run or pause leaves the value unchanged.
- R4: Writing state 2 (clear) shows state 2 for exactly one cycle, with `fifo_flush` high in that same cycle. The state then falls back to 0.
- R5: A write to address 0 while VALID is 0 is ignored: the state is unchanged. It sets a sticky error flag at status bit 0, and writing 1 to that bit clears it.
- R6: In run, `out_en` (or `in_en`) is high while that direction's word count, readable at address 5 (or 6), is below its limit. Each `out_word`/`in_word` pulse seen while the enable is high adds one. Pause drops both enables and holds the counts. Run entered from pause resumes from the held counts. Run entered from reset restarts both counts at 0.
- R7: When a direction's count reaches its limit, a sticky done flag is set: status bit 10 for transmit, bit 11 for receive. The enable for that direction drops, and further pulses are not counted. A limit of 0 never enables its direction. Done flags are cleared by writing 1 to them and by leaving reset.
- R8: An accepted write of state 0 while in run or pause drives `fifo_flush` high for exactly one cycle and drops both enables.
- R9: Writing 1 to bit 0 of address 1 is always accepted, even while VALID is 0. It returns the state to 0, clears the limits, counts and status bits, pulses `fifo_flush` for one cycle, and holds VALID at 0 for RST_SETTLE cycles (8 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr`, combinational |
| dp_ready | input | 1 | Data path confirms it has taken up the new state |
| out_word | input | 1 | One transmit word moved (pulse) |
| in_word | input | 1 | One receive word moved (pulse) |
| out_en | output | 1 | Transmit path may move words |
| in_en | output | 1 | Receive path may move words |
| fifo_flush | output | 1 | One-cycle request to empty both FIFOs |

## Verification
The bench times the VALID low window edge by edge. A settle counter that is off by one would show VALID rising a cycle early or late. A design that ignored `dp_ready` would raise VALID while the data path is still holding back. It writes the state register a second time inside that window: a design that accepts the early write would move to pause and never set the error flag. It pauses in the middle of a transfer and pulses words while paused, which catches a design that loses or keeps counting words in pause. It also catches a design that restarts the count on resume. Finally it drives the limit boundary, a zero limit, a limit write while running, the one-cycle clear state, and a software reset issued while VALID is low. Each of these shows up directly in the count readback, the flags or the flush pulse.

// File: rtl/scc_pkg.sv
package scc_pkg;

   typedef enum logic [1:0] {
      ST_RESET = 2'd0,
      ST_RUN   = 2'd1,
      ST_CLEAR = 2'd2,
      ST_PAUSE = 2'd3
   } core_st_e;

   // register offsets
   localparam int unsigned A_STATE   = 0;
   localparam int unsigned A_SWRST   = 1;
   localparam int unsigned A_OUT_LIM = 2;
   localparam int unsigned A_IN_LIM  = 3;
   localparam int unsigned A_STATUS  = 4;
   localparam int unsigned A_OUT_PRG = 5;
   localparam int unsigned A_IN_PRG  = 6;

   // bit positions
   localparam int unsigned B_VALID    = 2;
   localparam int unsigned B_ERR      = 0;
   localparam int unsigned B_OUT_DONE = 10;
   localparam int unsigned B_IN_DONE  = 11;

endpackage

// File: rtl/scc_settle.sv
// Holds the "transition in progress" condition: a fixed settle window,
// then a wait for the data path to confirm.
module scc_settle #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] len_m1,
   input  logic             ready,
   output logic             busy
);

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else if (start) begin
         cnt_q  <= len_m1;
         busy_q <= 1'b1;
      end else if (busy_q) begin
         if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
         else if (ready)
            busy_q <= 1'b0;
      end
   end

   assign busy = busy_q;

   // R2: while the window is still counting, the transition cannot complete
   p_window_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cnt_q != '0) |=> busy_q);

   // R2: without data path confirmation the busy state persists
   p_wait_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !ready && !start) |=> busy_q);

endmodule

// File: rtl/scc_xfer_counter.sv
// Word counter for one transfer direction, compared against its limit.
module scc_xfer_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [CNT_W-1:0] limit,
   input  logic             tick,
   output logic [CNT_W-1:0] progress,
   output logic             active,
   output logic             done_set
);

   logic [CNT_W-1:0] prog_q;

   assign active   = (prog_q < limit);
   assign done_set = tick && active && (prog_q == limit - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         prog_q <= '0;
      else if (restart)
         prog_q <= '0;
      else if (tick && active)
         prog_q <= prog_q + 1'b1;
   end

   assign progress = prog_q;

   // R7: reaching the limit ends this direction's activity
   p_done_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_set && !restart) |=> !active);

   // R7: the count never steps past its limit
   p_no_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !restart) |=> $stable(prog_q));

endmodule

// File: rtl/scc_run_ctrl.sv
module scc_run_ctrl
   import scc_pkg::*;
#(
   parameter int unsigned ADDR_W     = 3,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned SETTLE     = 3,
   parameter int unsigned RST_SETTLE = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              dp_ready,
   input  logic              out_word,
   input  logic              in_word,
   output logic              out_en,
   output logic              in_en,
   output logic              fifo_flush
);

   localparam int unsigned SET_MAX = (SETTLE > RST_SETTLE) ? SETTLE : RST_SETTLE;
   localparam int unsigned SET_W   = $clog2(SET_MAX + 1);
   localparam int unsigned NDIR    = 2;

   if (SETTLE < 1 || RST_SETTLE < 1) begin : g_bad_settle
      $error("scc_run_ctrl: settle lengths must be at least 1");
   end
   if (DATA_W < 12 || DATA_W < CNT_W) begin : g_bad_data
      $error("scc_run_ctrl: DATA_W must hold the status bits and a count");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("scc_run_ctrl: ADDR_W too small for the register map");
   end

   // ---------------- decode ----------------
   core_st_e state_q;
   core_st_e req_st;
   logic     busy, valid;
   logic     wr_state, wr_swrst, wr_status, state_acc, leave_reset, flush_req;
   logic     err_q, flush_q;
   logic     unused_wbits;

   assign valid     = !busy;
   assign req_st    = core_st_e'(reg_wdata[1:0]);
   assign wr_state  = reg_wr && (reg_addr == ADDR_W'(A_STATE));
   assign wr_swrst  = reg_wr && (reg_addr == ADDR_W'(A_SWRST)) && reg_wdata[0];
   assign wr_status = reg_wr && (reg_addr == ADDR_W'(A_STATUS));
   assign state_acc = wr_state && valid;
   assign leave_reset = state_acc && (state_q == ST_RESET) &&
                        (req_st == ST_RUN || req_st == ST_PAUSE);
   assign flush_req = wr_swrst ||
                      (state_acc && (req_st == ST_CLEAR ||
                       (req_st == ST_RESET &&
                        (state_q == ST_RUN || state_q == ST_PAUSE))));
   assign unused_wbits = ^reg_wdata;

   // ---------------- state register ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state_q <= ST_RESET;
      else if (wr_swrst)
         state_q <= ST_RESET;
      else if (state_acc)
         state_q <= req_st;
      else if (state_q == ST_CLEAR)
         state_q <= ST_RESET;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         err_q <= 1'b0;
      else if (wr_swrst)
         err_q <= 1'b0;
      else if (wr_state && !valid)
         err_q <= 1'b1;
      else if (wr_status && reg_wdata[B_ERR])
         err_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flush_q <= 1'b0;
      else
         flush_q <= flush_req;
   end

   assign fifo_flush = flush_q;

   // ---------------- settle handshake ----------------
   scc_settle #(.CNT_W(SET_W)) u_settle (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (state_acc || wr_swrst),
      .len_m1 (wr_swrst ? SET_W'(RST_SETTLE - 1) : SET_W'(SETTLE - 1)),
      .ready  (dp_ready),
      .busy   (busy)
   );

   // ---------------- per-direction limits, counters, done flags ----------------
   logic [NDIR-1:0][CNT_W-1:0] lim_q;
   logic [NDIR-1:0][CNT_W-1:0] prog;
   logic [NDIR-1:0]            act, done_set, done_q, word;
   logic                       run_st;

   assign run_st = (state_q == ST_RUN);
   assign word   = {in_word, out_word};

   for (genvar d = 0; d < NDIR; d++) begin : g_dir
      localparam int unsigned LIM_A  = (d == 0) ? A_OUT_LIM : A_IN_LIM;
      localparam int unsigned DONE_B = (d == 0) ? B_OUT_DONE : B_IN_DONE;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lim_q[d] <= '0;
         else if (wr_swrst)
            lim_q[d] <= '0;
         else if (reg_wr && reg_addr == ADDR_W'(LIM_A) && state_q == ST_RESET)
            lim_q[d] <= reg_wdata[CNT_W-1:0];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            done_q[d] <= 1'b0;
         else if (wr_swrst || leave_reset)
            done_q[d] <= 1'b0;
         else if (done_set[d])
            done_q[d] <= 1'b1;
         else if (wr_status && reg_wdata[DONE_B])
            done_q[d] <= 1'b0;
      end

      scc_xfer_counter #(.CNT_W(CNT_W)) u_cnt (
         .clk      (clk),
         .rst_n    (rst_n),
         .restart  (wr_swrst || leave_reset),
         .limit    (lim_q[d]),
         .tick     (word[d] && run_st),
         .progress (prog[d]),
         .active   (act[d]),
         .done_set (done_set[d])
      );
   end

   assign out_en = run_st && act[0];
   assign in_en  = run_st && act[1];

   // ---------------- read mux ----------------
   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_W'(A_STATE): begin
            reg_rdata[1:0]     = state_q;
            reg_rdata[B_VALID] = valid;
         end
         ADDR_W'(A_OUT_LIM): reg_rdata[CNT_W-1:0] = lim_q[0];
         ADDR_W'(A_IN_LIM):  reg_rdata[CNT_W-1:0] = lim_q[1];
         ADDR_W'(A_STATUS): begin
            reg_rdata[B_ERR]      = err_q;
            reg_rdata[B_OUT_DONE] = done_q[0];
            reg_rdata[B_IN_DONE]  = done_q[1];
         end
         ADDR_W'(A_OUT_PRG): reg_rdata[CNT_W-1:0] = prog[0];
         ADDR_W'(A_IN_PRG):  reg_rdata[CNT_W-1:0] = prog[1];
         default: ;
      endcase
   end

   // ---------------- assertions ----------------
   p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      state_acc |=> !valid);

   p_limit_only_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(lim_q)) |-> ($past(state_q) == ST_RESET || $past(wr_swrst)));

   p_clear_falls_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CLEAR) |=> (state_q == ST_RESET));

   p_early_write_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_state && !valid && !wr_swrst && state_q != ST_CLEAR)
      |=> ($stable(state_q) && err_q));

   p_pause_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PAUSE && !wr_swrst) |=> $stable(prog));

   p_flush_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_q && !wr_swrst) |=> !flush_q);

   p_swrst_defaults_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_swrst |=> (state_q == ST_RESET && lim_q == '0 && !valid && fifo_flush));

endmodule

// File: tb/sim_scc_run_ctrl.sv
module sim_scc_run_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        dp_ready = 1'b1;
   logic        out_word = 1'b0;
   logic        in_word = 1'b0;
   logic        out_en, in_en, fifo_flush;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   scc_run_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dp_ready(dp_ready),
      .out_word(out_word), .in_word(in_word), .out_en(out_en),
      .in_en(in_en), .fifo_flush(fifo_flush)
   );

   localparam int ST = 0, SWR = 1, OLIM = 2, ILIM = 3, STAT = 4, OPRG = 5, IPRG = 6;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic adv();
      @(negedge clk);
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = 32'(d);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] v);
      reg_addr = 3'(a);
      #1;
      v = reg_rdata;
   endtask

   task automatic wait_valid();
      logic [31:0] v;
      for (int i = 0; i < 40; i++) begin
         rd(ST, v);
         if (v[2]) break;
         adv();
      end
   endtask

   task automatic go(input int st);
      wr(ST, st);
      wait_valid();
   endtask

   task automatic pulse(input bit is_out);
      @(negedge clk);
      if (is_out) out_word = 1'b1; else in_word = 1'b1;
      @(negedge clk);
      out_word = 1'b0; in_word = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(ST, v);   chk("R1 state after reset", v, 32'h4);
      rd(OLIM, v); chk("R1 tx limit", v, 0);
      rd(ILIM, v); chk("R1 rx limit", v, 0);
      rd(STAT, v); chk("R1 status", v, 0);
      chk("R1 enables/flush", {29'd0, out_en, in_en, fifo_flush}, 0);
   endtask

   task automatic t_handshake();
      logic [31:0] v;
      wr(ST, 1);
      rd(ST, v); chk("R2 run shown, VALID low c1", v, 32'h1);
      adv(); rd(ST, v); chk("R2 VALID low c2", v[2], 0);
      adv(); rd(ST, v); chk("R2 VALID low c3", v[2], 0);
      adv(); rd(ST, v); chk("R2 VALID back after 3", v, 32'h5);
      go(0);
      dp_ready = 1'b0;
      wr(ST, 3);
      repeat (5) adv();
      rd(ST, v); chk("R2 VALID waits for dp_ready", v, 32'h3);
      dp_ready = 1'b1;
      adv(); rd(ST, v); chk("R2 VALID after dp_ready", v, 32'h7);
      go(0);
   endtask

   task automatic t_limits();
      logic [31:0] v;
      wr(OLIM, 5); rd(OLIM, v); chk("R3 tx limit written in reset", v, 5);
      wr(ILIM, 16'hFFFF); rd(ILIM, v); chk("R3 rx limit 16-bit max", v, 32'hFFFF);
      go(1);
      wr(OLIM, 9); rd(OLIM, v); chk("R3 tx limit write in run ignored", v, 5);
      go(3);
      wr(ILIM, 7); rd(ILIM, v); chk("R3 rx limit write in pause ignored", v, 32'hFFFF);
      go(0);
   endtask

   task automatic t_ignored();
      logic [31:0] v;
      wr(ST, 1);
      wr(ST, 3);
      rd(ST, v); chk("R5 early write ignored", v[1:0], 1);
      rd(STAT, v); chk("R5 error flag set", v[0], 1);
      wait_valid();
      rd(ST, v); chk("R5 state still run", v, 32'h5);
      wr(STAT, 1); rd(STAT, v); chk("R5 error W1C", v[0], 0);
      go(0);
   endtask

   task automatic t_run_pause();
      logic [31:0] v;
      wr(OLIM, 3); wr(ILIM, 2);
      go(1);
      rd(OPRG, v); chk("R6 tx count restarts at 0", v, 0);
      chk("R6 enables in run", {30'd0, out_en, in_en}, 3);
      pulse(1); pulse(1);
      rd(OPRG, v); chk("R6 two tx words counted", v, 2);
      go(3);
      chk("R6 enables off in pause", {30'd0, out_en, in_en}, 0);
      pulse(1);
      rd(OPRG, v); chk("R6 pause holds count", v, 2);
      go(1);
      rd(OPRG, v); chk("R6 resume keeps count", v, 2);
      pulse(1);
      rd(OPRG, v); chk("R7 tx count at limit", v, 3);
      rd(STAT, v); chk("R7 tx done bit10", v, 32'h400);
      chk("R7 tx enable drops", out_en, 0);
      pulse(1);
      rd(OPRG, v); chk("R7 extra tx word ignored", v, 3);
      pulse(0); pulse(0);
      rd(STAT, v); chk("R7 rx done bit11", v, 32'hC00);
      wr(STAT, 32'h400); rd(STAT, v); chk("R7 done W1C", v, 32'h800);
   endtask

   task automatic t_flush();
      logic [31:0] v;
      wr(ST, 0);
      chk("R8 flush pulse on stop", fifo_flush, 1);
      chk("R8 enables off", {30'd0, out_en, in_en}, 0);
      adv(); chk("R8 flush one cycle", fifo_flush, 0);
      wait_valid();
      wr(ST, 0);
      chk("R8 no flush reset->reset", fifo_flush, 0);
      wait_valid();
   endtask

   task automatic t_zero_limit();
      logic [31:0] v;
      wr(OLIM, 0); wr(ILIM, 1);
      go(1);
      chk("R7 zero limit never enables", {30'd0, out_en, in_en}, 1);
      rd(STAT, v); chk("R7 leaving reset clears done", v, 0);
      go(0);
   endtask

   task automatic t_clear();
      logic [31:0] v;
      go(1);
      wr(ST, 2);
      rd(ST, v); chk("R4 clear state shown", v[1:0], 2);
      chk("R4 flush with clear", fifo_flush, 1);
      adv(); rd(ST, v); chk("R4 clear falls to reset", v[1:0], 0);
      chk("R4 flush one cycle", fifo_flush, 0);
      wait_valid();
   endtask

   task automatic t_swrst();
      logic [31:0] v;
      wr(OLIM, 4); wr(ILIM, 6);
      go(1);
      pulse(1);
      wr(ST, 3);
      wr(SWR, 1);
      rd(ST, v); chk("R9 state reset, VALID low", v, 0);
      chk("R9 flush pulse", fifo_flush, 1);
      rd(OLIM, v); chk("R9 tx limit cleared", v, 0);
      rd(ILIM, v); chk("R9 rx limit cleared", v, 0);
      rd(OPRG, v); chk("R9 tx count cleared", v, 0);
      repeat (7) adv();
      rd(ST, v); chk("R9 VALID low 8 cycles", v[2], 0);
      adv(); rd(ST, v); chk("R9 VALID back", v, 32'h4);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      adv();
      t_reset();
      t_handshake();
      t_limits();
      t_ignored();
      t_run_pause();
      t_flush();
      t_zero_limit();
      t_clear();
      t_swrst();
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule